// File: doc/BRIEF.md
# Floating-Point Power-of-Two Scaler

This unit divides an IEEE 754 floating-point value by 2^k without a divider. Only the biased exponent is reduced by k. The sign and the mantissa pass through untouched as long as the result is still a normal number. A typical use is normalising an accumulated sum by a power-of-two frame length, such as a 256-point block, which gives k = 8.

One parameter selects the format: binary16 or binary32. Each accepted operand produces a registered result and a valid strobe one clock later. Special inputs are handled as follows:

- Zeros and infinities pass through unchanged.
- NaNs come back quiet.
- A result that falls out of the normal range is denormalised by truncating right shifts of the mantissa.
- A result that shifts away to nothing flushes to a signed zero and raises an underflow flag.

Top module: `fp_pow2_div`

## Requirements
- R1: For a normal operand with biased exponent e > k, the result has exponent e − k and the same sign and mantissa bits.
- R2: With k = 0, any operand that is not a NaN is returned bit for bit.
- R3: A zero or infinity operand (either sign) is returned unchanged, with the underflow flag low.
- R4: A NaN operand (exponent all ones, mantissa nonzero) is returned with the mantissa's top bit (quiet bit) forced to 1 and every other bit unchanged.
- R5: For a normal operand with 1 ≤ e ≤ k, the result is built as follows. The exponent field is 0. The mantissa field is the value {1, mantissa} shifted right by k − e + 1 and truncated. The sign is kept. If that mantissa is nonzero, the underflow flag stays low.
- R6: For a subnormal operand (exponent 0, mantissa nonzero), the result keeps exponent 0 and the sign, and its mantissa is the input mantissa shifted right by k, truncated.
- R7: If the shifted mantissa of R5 or R6 is zero, the result is a zero with the operand's sign and out_uflow is 1. In every other case out_uflow is 0.
- R8: The result appears one cycle after in_valid is sampled high. out_valid is high exactly in the cycle after in_valid, and out_uflow is never high without out_valid.
- R9: In a cycle after in_valid is low, out_valid is 0 and out_res keeps its previous value.
- R10: While rst_n is low, out_valid, out_res and out_uflow are all 0.
- R11: The FP_W parameter selects the field layout. FP_W = 16 gives 1 sign bit, a 5-bit exponent (bias 15) and a 10-bit mantissa. FP_W = 32 gives 1 sign bit, an 8-bit exponent (bias 127) and a 23-bit mantissa. The sign is the top bit and the mantissa occupies the low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand and shift amount are valid |
| in_op | input | FP_W | Floating-point operand |
| in_k | input | 5 | Power-of-two exponent k, 0 to 31 |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_res | output | FP_W | Scaled floating-point result |
| out_uflow | output | 1 | Result flushed to signed zero |

## Verification
Every result, including out_valid and out_uflow, is due exactly one rising edge after the operand is presented. The bench drives each operand on a falling edge and compares the outputs on the next falling edge. At that point exactly one register stage has updated and the inputs are stable. Idle cycles are inserted the same way, and on the following falling edge the bench confirms that out_valid has dropped and that out_res has held. The binary16 instance is swept over every exponent, both signs, all 32 shift amounts and a spread of mantissas. The binary32 instance is swept over the exponents near its boundaries.

// File: rtl/fp_pow2_pkg.sv
package fp_pow2_pkg;
    localparam int K_W = 5;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_cls_e;
endpackage

// File: rtl/fp_pow2_classify.sv
module fp_pow2_classify #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  logic [EXP_W-1:0]     exp_i,
    input  logic [MAN_W-1:0]     man_i,
    output fp_pow2_pkg::fp_cls_e cls_o
);
    import fp_pow2_pkg::*;

    logic exp_max, exp_min, man_zero;

    always_comb begin
        exp_max  = &exp_i;
        exp_min  = ~|exp_i;
        man_zero = ~|man_i;
        if (exp_max)       cls_o = man_zero ? CLS_INF : CLS_NAN;
        else if (exp_min)  cls_o = man_zero ? CLS_ZERO : CLS_SUB;
        else               cls_o = CLS_NORM;
    end
endmodule

// File: rtl/fp_pow2_scale.sv
module fp_pow2_scale #(
    parameter int EXP_W = 5,
    parameter int MAN_W = 10
) (
    input  fp_pow2_pkg::fp_cls_e          cls_i,
    input  logic [EXP_W-1:0]              exp_i,
    input  logic [MAN_W-1:0]              man_i,
    input  logic [fp_pow2_pkg::K_W-1:0]   k_i,
    output logic [EXP_W-1:0]              exp_o,
    output logic [MAN_W-1:0]              man_o,
    output logic                          zero_o
);
    import fp_pow2_pkg::*;

    localparam int CW = (EXP_W > K_W) ? EXP_W + 1 : K_W + 1;

    logic [CW-1:0]    e_w, k_w, s_w, diff_w;
    logic [MAN_W:0]   sig;
    logic [MAN_W:0]   shifted;

    always_comb begin
        e_w     = CW'(exp_i);
        k_w     = CW'(k_i);
        diff_w  = e_w - k_w;
        s_w     = k_w - e_w + CW'(1);
        sig     = {1'b1, man_i};
        shifted = '0;
        exp_o   = exp_i;
        man_o   = man_i;
        if (cls_i == CLS_NORM) begin
            if (e_w > k_w) begin
                exp_o = diff_w[EXP_W-1:0];
            end else begin
                shifted = sig >> s_w;
                exp_o   = '0;
                man_o   = shifted[MAN_W-1:0];
            end
        end else if (cls_i == CLS_SUB) begin
            man_o = man_i >> k_i;
        end
        zero_o = ((cls_i == CLS_NORM) || (cls_i == CLS_SUB)) &&
                 (exp_o == '0) && (man_o == '0);
    end
endmodule

// File: rtl/fp_pow2_div.sv
module fp_pow2_div #(
    parameter int FP_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [FP_W-1:0]               in_op,
    input  logic [fp_pow2_pkg::K_W-1:0]   in_k,
    output logic                          out_valid,
    output logic [FP_W-1:0]               out_res,
    output logic                          out_uflow
);
    import fp_pow2_pkg::*;

    localparam int EXP_W = (FP_W == 32) ? 8 : 5;
    localparam int MAN_W = FP_W - EXP_W - 1;

    typedef struct packed {
        logic            valid;
        logic [FP_W-1:0] res;
        logic            uflow;
    } state_t;

    state_t state_d, state_q;

    logic             sgn;
    logic [EXP_W-1:0] exp_f, exp_s;
    logic [MAN_W-1:0] man_f, man_s;
    logic             zero_s;
    fp_cls_e          cls;

    assign sgn   = in_op[FP_W-1];
    assign exp_f = in_op[FP_W-2:MAN_W];
    assign man_f = in_op[MAN_W-1:0];

    fp_pow2_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
        .exp_i (exp_f),
        .man_i (man_f),
        .cls_o (cls)
    );

    fp_pow2_scale #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_scale (
        .cls_i  (cls),
        .exp_i  (exp_f),
        .man_i  (man_f),
        .k_i    (in_k),
        .exp_o  (exp_s),
        .man_o  (man_s),
        .zero_o (zero_s)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        state_d.uflow = 1'b0;
        if (in_valid) begin
            unique case (cls)
                CLS_ZERO, CLS_INF: state_d.res = in_op;
                CLS_NAN: state_d.res = {sgn, exp_f, 1'b1, man_f[MAN_W-2:0]};
                default: begin
                    state_d.res   = {sgn, exp_s, man_s};
                    state_d.uflow = zero_s;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign out_valid = state_q.valid;
    assign out_res   = state_q.res;
    assign out_uflow = state_q.uflow;
endmodule

// File: rtl/fp_pow2_div_chk.sv
module fp_pow2_div_chk #(
    parameter int FP_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [FP_W-1:0] in_op,
    input logic [4:0]      in_k,
    input logic            out_valid,
    input logic [FP_W-1:0] out_res,
    input logic            out_uflow
);
    localparam int EXP_W = (FP_W == 32) ? 8 : 5;
    localparam int MAN_W = FP_W - EXP_W - 1;

    logic in_nan;
    assign in_nan = (&in_op[FP_W-2:MAN_W]) && (|in_op[MAN_W-1:0]);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);                                         // R8
    AST_IDLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                       // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_res));                                 // R9
    AST_UFLOW_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_uflow |-> out_valid);                                        // R8
    AST_UFLOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_uflow |-> (out_res[FP_W-2:0] == '0));                        // R7
    AST_K0_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_k == 5'd0 && !in_nan) |=> (out_res == $past(in_op))); // R2
    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_res[FP_W-1] == $past(in_op[FP_W-1])));         // R1
endmodule

bind fp_pow2_div fp_pow2_div_chk #(.FP_W(FP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_k      (in_k),
    .out_valid (out_valid),
    .out_res   (out_res),
    .out_uflow (out_uflow)
);

// File: tb/fp_pow2_div_tb.sv
module fp_pow2_div_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        v16 = 1'b0, v32 = 1'b0;
    logic [15:0] op16 = '0;
    logic [31:0] op32 = '0;
    logic [4:0]  k16 = '0, k32 = '0;
    logic        ov16, ov32, uf16, uf32;
    logic [15:0] res16;
    logic [31:0] res32;

    int total = 0;
    int bad = 0;
    bit done = 0;

    fp_pow2_div #(.FP_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .in_op(op16), .in_k(k16),
        .out_valid(ov16), .out_res(res16), .out_uflow(uf16));

    fp_pow2_div #(.FP_W(32)) u_dut32 (
        .clk(clk), .rst_n(rst_n), .in_valid(v32), .in_op(op32), .in_k(k32),
        .out_valid(ov32), .out_res(res32), .out_uflow(uf32));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference from the requirements: value = M * 2^(E - bias - mw)
    function automatic logic [31:0] ref_div(input int ew, input int mw,
            input logic [31:0] x, input int k, output logic uf, output string tag);
        int emax, e, ne;
        logic [31:0] m, mm, q, sbit;
        emax = (1 << ew) - 1;
        sbit = x & (32'd1 << (ew + mw));
        e    = int'((x >> mw) & emax);
        m    = x & ((32'd1 << mw) - 1);
        uf   = 1'b0;
        if (e == emax) begin
            tag = (m != 0) ? "R4" : "R3";
            return (m != 0) ? (x | (32'd1 << (mw - 1))) : x;
        end
        if (e == 0 && m == 0) begin tag = "R3"; return x; end
        if (k == 0) begin tag = "R2"; return x; end
        mm = (e == 0) ? m : (m | (32'd1 << mw));
        ne = ((e == 0) ? 1 : e) - k;
        if (ne >= 1) begin
            tag = "R1";
            return sbit | (32'(ne) << mw) | m;
        end
        q   = mm >> (1 - ne);
        tag = (e == 0) ? "R6" : "R5";
        if (q == 0) begin uf = 1'b1; tag = "R7"; end
        return sbit | q;
    endfunction

    task automatic run16(input logic [15:0] x, input int k);
        logic [31:0] exp;
        logic euf;
        string tag;
        exp = ref_div(5, 10, {16'd0, x}, k, euf, tag);
        v16 = 1'b1; op16 = x; k16 = 5'(k);
        @(negedge clk);
        chk(ov16 && res16 == exp[15:0] && uf16 == euf,
            {tag, " R11 R8 b16"}, {15'd0, uf16, res16}, {15'd0, euf, exp[15:0]});
    endtask

    task automatic run32(input logic [31:0] x, input int k);
        logic [31:0] exp;
        logic euf;
        string tag;
        exp = ref_div(8, 23, x, k, euf, tag);
        v32 = 1'b1; op32 = x; k32 = 5'(k);
        @(negedge clk);
        chk(ov32 && res32 == exp && uf32 == euf, {tag, " R11 b32"}, res32, exp);
        chk(uf32 == euf, "R7 b32 flag", {31'd0, uf32}, {31'd0, euf});
    endtask

    initial begin
        logic [15:0] held;
        int mans16 [8] = '{0, 1, 2, 'h155, 'h200, 'h2AA, 'h3FF, 'h17};
        int exps32 [10] = '{0, 1, 2, 5, 30, 126, 127, 200, 254, 255};
        int mans32 [4] = '{0, 1, 'h400000, 'h7FFFFF};
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ov16 == 0 && res16 == 0 && uf16 == 0, "R10 b16", {15'd0, uf16, res16}, 0);
        chk(ov32 == 0 && res32 == 0 && uf32 == 0, "R10 b32", res32, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed: 1.0 / 256 in binary16 -> exponent 15-8=7
        run16(16'h3C00, 8);
        chk(res16 == 16'h1C00, "R1 directed", {16'd0, res16}, 32'h1C00);
        // Sweep binary16
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 32; e++)
                for (int mi = 0; mi < 8; mi++)
                    for (int k = 0; k < 32; k++)
                        run16({1'(s), 5'(e), 10'(mans16[mi])}, k);
        // R9: idle cycle holds result, drops valid and flag
        run16(16'h8001, 1);       // R7 underflow, signed zero
        held = res16;
        v16 = 1'b0; op16 = 16'h4000; k16 = 5'd0;
        @(negedge clk);
        chk(!ov16 && res16 == held && !uf16, "R9 idle", {15'd0, ov16, res16}, {16'd0, held});
        // Sweep binary32
        for (int s = 0; s < 2; s++)
            for (int ei = 0; ei < 10; ei++)
                for (int mi = 0; mi < 4; mi++)
                    for (int k = 0; k < 32; k++)
                        run32({1'(s), 8'(exps32[ei]), 23'(mans32[mi])}, k);
        v32 = 1'b0;
        @(negedge clk);
        chk(!ov32, "R8 b32 valid drop", {31'd0, ov32}, 0);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule